// File: doc/BRIEF.md
# PCIe Address Translation Window Unit

This block holds two banks of programmable address-translation windows, one for inbound traffic and one for outbound traffic. Software reaches a single window at a time through a selector register that names a direction and a window number. It then programs that window's base, limit, target and type through a small group of fixed register offsets. A lookup port takes an address and a direction. In the same cycle it reports whether an enabled window of that direction covers the address, which window matched, and the result of the match. For a memory window the result is the translated address. For a configuration window it is a bus number, a device/function number and a register offset. On a miss the caller passes the access through unchanged.

Base, limit, target and type writes land in shadow storage. The decode used by lookups is refreshed only when the selected window's control register is written. This lets software rewrite a live window without lookups ever seeing a half-programmed window. The number of windows per direction and the width of the configuration offset are parameters.

Top module: `atw_unit`

## Requirements
- R1: After reset every window has base 0, limit 0xFFFF_FFFF, target 0, memory type and is disabled, except inbound window 0, which is enabled. An inbound lookup below 0x1_0000_0000 therefore hits window 0 with the address unchanged, and an outbound lookup misses.
- R2: The selector register at offset 0x900 holds the direction in bit 31 (1 = inbound, 0 = outbound) and the window number in bits 3:0, and reads back those fields. A window number of at least the window count selects nothing: window register writes are ignored and window register reads return 0.
- R3: Writes to base, limit, target and type change only readback. Lookups use the new values only after a write to the control register at 0x908, whose bit 31 sets the enable. Control bit 31 reads back at bit 31.
- R4: Base low at 0x90C and base high at 0x910 write bits 31:0 and 63:32 of the 64-bit base, each leaving the other half unchanged. Target low at 0x918 and target high at 0x91C behave the same way on the target. The limit is at 0x914.
- R5: A window covers an address A when base <= A and A < limit + 1, with the limit zero-extended to 64 bits. A window whose base is above its limit covers nothing.
- R6: On a hit in a memory-type window, the translated address equals target + (A - base), modulo 2^64.
- R7: The type register at 0x904 makes a window a configuration window when it is nonzero. On such a hit the configuration flag is 1, the bus is target bits 31:24, the device/function is target bits 23:16, and the offset is the low CFG_OFF_W bits of A.
- R8: When several enabled windows of one direction cover A, the lowest-numbered one wins, and its number appears on the index output.
- R9: On a miss the hit and configuration flags are 0, the index is 0, and the address output equals A.
- R10: A lookup consults only the windows of the direction it names.
- R11: Register offsets outside the eight defined ones read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| lk_addr | input | 64 | Lookup address |
| lk_inbound | input | 1 | Lookup direction, 1 = inbound |
| lk_hit | output | 1 | An enabled window covers the address |
| lk_cfg | output | 1 | The matching window is configuration type |
| lk_xaddr | output | 64 | Translated address, or lk_addr when not a memory hit |
| lk_bus | output | 8 | Configuration bus number |
| lk_devfn | output | 8 | Configuration device/function number |
| lk_cfg_off | output | CFG_OFF_W | Configuration register offset |
| lk_index | output | clog2(NUM_WIN) | Number of the matching window |

## Verification
The lookup checks are clocked samples of a combinational path. They assume that lk_addr and lk_inbound are steady around each rising edge and that reg_wr is never unknown once reset is released. The bench changes every input only on the falling edge and holds reg_wr low except for single-cycle writes. It programs windows only while they are disabled or through the control write, so that no half-written window is looked up. Windows are given limits at or above their base, except in the one case that tests an inverted window. Configuration windows are placed in address ranges the memory windows do not reach, so that each check has one intended winner, apart from the overlaps built on purpose.

// File: rtl/atw_pkg.sv
package atw_pkg;

  // Register offsets of the selector and of the selected window
  localparam logic [11:0] OFF_VIEW    = 12'h900;
  localparam logic [11:0] OFF_TYPE    = 12'h904;
  localparam logic [11:0] OFF_CTRL    = 12'h908;
  localparam logic [11:0] OFF_BASE_LO = 12'h90C;
  localparam logic [11:0] OFF_BASE_HI = 12'h910;
  localparam logic [11:0] OFF_LIMIT   = 12'h914;
  localparam logic [11:0] OFF_TGT_LO  = 12'h918;
  localparam logic [11:0] OFF_TGT_HI  = 12'h91C;

  localparam int CTRL_EN_BIT = 31;
  localparam int VIEW_DIR_BIT = 31;
  localparam int VIEW_IDX_W = 4;

  typedef struct packed {
    logic [63:0] base;
    logic [31:0] limit;
    logic [63:0] target;
    logic        cfg;
    logic        en;
  } win_t;

  function automatic win_t win_reset(input logic inbound, input int idx);
    win_t w;
    w.base   = 64'd0;
    w.limit  = 32'hFFFF_FFFF;
    w.target = 64'd0;
    w.cfg    = 1'b0;
    w.en     = inbound && (idx == 0);
    return w;
  endfunction

endpackage

// File: rtl/atw_rst_sync.sv
module atw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/atw_regfile.sv
module atw_regfile
  import atw_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [11:0]                   reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output win_t [1:0][NUM_WIN-1:0]       act_o
);

  logic                           view_dir_q, view_dir_d;
  logic [VIEW_IDX_W-1:0]          view_idx_q, view_idx_d;
  win_t [1:0][NUM_WIN-1:0]        shd_q, shd_d;
  win_t [1:0][NUM_WIN-1:0]        act_q, act_d;
  logic [1:0][NUM_WIN-1:0][31:0]  typ_q, typ_d;

  logic               sel_ok;
  logic [IDX_W-1:0]   sidx;
  win_t               cur;
  logic [31:0]        cur_typ;

  assign sel_ok  = (32'(view_idx_q) < NUM_WIN);
  assign sidx    = view_idx_q[IDX_W-1:0];
  assign cur     = shd_q[view_dir_q][sidx];
  assign cur_typ = typ_q[view_dir_q][sidx];

  // Next-state logic
  always_comb begin
    view_dir_d = view_dir_q;
    view_idx_d = view_idx_q;
    shd_d      = shd_q;
    act_d      = act_q;
    typ_d      = typ_q;
    if (reg_addr == OFF_VIEW) begin
      view_dir_d = reg_wdata[VIEW_DIR_BIT];
      view_idx_d = reg_wdata[VIEW_IDX_W-1:0];
    end else if (sel_ok) begin
      unique case (reg_addr)
        OFF_TYPE: begin
          typ_d[view_dir_q][sidx]     = reg_wdata;
          shd_d[view_dir_q][sidx].cfg = (reg_wdata != 32'd0);
        end
        OFF_CTRL: begin
          shd_d[view_dir_q][sidx].en = reg_wdata[CTRL_EN_BIT];
          act_d[view_dir_q][sidx]    = cur;
          act_d[view_dir_q][sidx].en = reg_wdata[CTRL_EN_BIT];
        end
        OFF_BASE_LO: shd_d[view_dir_q][sidx].base[31:0]    = reg_wdata;
        OFF_BASE_HI: shd_d[view_dir_q][sidx].base[63:32]   = reg_wdata;
        OFF_LIMIT:   shd_d[view_dir_q][sidx].limit         = reg_wdata;
        OFF_TGT_LO:  shd_d[view_dir_q][sidx].target[31:0]  = reg_wdata;
        OFF_TGT_HI:  shd_d[view_dir_q][sidx].target[63:32] = reg_wdata;
        default: ;
      endcase
    end
  end

  // State registers, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_dir_q <= 1'b0;
      view_idx_q <= '0;
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          shd_q[d][w] <= win_reset(d == 1, w);
          act_q[d][w] <= win_reset(d == 1, w);
          typ_q[d][w] <= 32'd0;
        end
      end
    end else if (reg_wr) begin
      view_dir_q <= view_dir_d;
      view_idx_q <= view_idx_d;
      shd_q      <= shd_d;
      act_q      <= act_d;
      typ_q      <= typ_d;
    end
  end

  // Read path
  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr == OFF_VIEW) begin
      reg_rdata = {view_dir_q, {(31-VIEW_IDX_W){1'b0}}, view_idx_q};
    end else if (sel_ok) begin
      unique case (reg_addr)
        OFF_TYPE:    reg_rdata = cur_typ;
        OFF_CTRL:    reg_rdata = {cur.en, 31'd0};
        OFF_BASE_LO: reg_rdata = cur.base[31:0];
        OFF_BASE_HI: reg_rdata = cur.base[63:32];
        OFF_LIMIT:   reg_rdata = cur.limit;
        OFF_TGT_LO:  reg_rdata = cur.target[31:0];
        OFF_TGT_HI:  reg_rdata = cur.target[63:32];
        default:     reg_rdata = 32'd0;
      endcase
    end
  end

  assign act_o = act_q;

  AST_UNSELECTED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !sel_ok && reg_addr != OFF_VIEW) |=> ($stable(shd_q) && $stable(act_q) && $stable(typ_q))); // R2

  AST_ACTIVE_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel_ok && reg_addr == OFF_CTRL) |=> $stable(act_q)); // R3

  AST_UNMAPPED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr < OFF_VIEW || reg_addr > OFF_TGT_HI || reg_addr[1:0] != 2'b00))
      |=> ($stable(shd_q) && $stable(act_q) && $stable(view_idx_q) && $stable(view_dir_q))); // R11

endmodule

// File: rtl/atw_match.sv
module atw_match
  import atw_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int IDX_W     = 2,
  parameter int CFG_OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  win_t [NUM_WIN-1:0]    wins_i,
  input  logic [63:0]           addr_i,
  output logic                  hit_o,
  output logic                  cfg_o,
  output logic [63:0]           xaddr_o,
  output logic [7:0]            bus_o,
  output logic [7:0]            devfn_o,
  output logic [CFG_OFF_W-1:0]  off_o,
  output logic [IDX_W-1:0]      idx_o
);

  logic [NUM_WIN-1:0] hit_vec;
  logic [IDX_W-1:0]   sel;
  win_t               w;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [32:0] end_excl;
    assign end_excl   = {1'b0, wins_i[g].limit} + 33'd1;
    assign hit_vec[g] = wins_i[g].en
                        && (addr_i >= wins_i[g].base)
                        && (addr_i < {31'd0, end_excl});
  end

  // Lowest-numbered hit wins
  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
  end

  assign w     = wins_i[sel];
  assign hit_o = |hit_vec;
  assign idx_o = sel;

  always_comb begin
    cfg_o   = 1'b0;
    xaddr_o = addr_i;
    bus_o   = 8'd0;
    devfn_o = 8'd0;
    off_o   = '0;
    if (hit_o) begin
      if (w.cfg) begin
        cfg_o   = 1'b1;
        bus_o   = w.target[31:24];
        devfn_o = w.target[23:16];
        off_o   = addr_i[CFG_OFF_W-1:0];
      end else begin
        xaddr_o = w.target + (addr_i - w.base);
      end
    end
  end

  logic [NUM_WIN-1:0] below_mask;
  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) below_mask[i] = (i < 32'(idx_o));
  end

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (xaddr_o == addr_i && !cfg_o && idx_o == '0)); // R9

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (hit_vec[idx_o] && ((hit_vec & below_mask) == '0))); // R8

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (addr_i >= wins_i[idx_o].base && addr_i <= {32'd0, wins_i[idx_o].limit})); // R5

  AST_MEM_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !cfg_o) |-> ((xaddr_o - wins_i[idx_o].target) == (addr_i - wins_i[idx_o].base))); // R6

endmodule

// File: rtl/atw_unit.sv
module atw_unit
  import atw_pkg::*;
#(
  parameter int NUM_WIN   = 4,   // windows per direction, 2..16
  parameter int CFG_OFF_W = 12   // log2 of configuration space size
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [11:0]                  reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic [63:0]                  lk_addr,
  input  logic                         lk_inbound,
  output logic                         lk_hit,
  output logic                         lk_cfg,
  output logic [63:0]                  lk_xaddr,
  output logic [7:0]                   lk_bus,
  output logic [7:0]                   lk_devfn,
  output logic [CFG_OFF_W-1:0]         lk_cfg_off,
  output logic [$clog2(NUM_WIN)-1:0]   lk_index
);

  localparam int IDX_W = $clog2(NUM_WIN);

  logic                     rst_n_int;
  win_t [1:0][NUM_WIN-1:0]  act;
  win_t [NUM_WIN-1:0]       dir_wins;

  atw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  atw_regfile #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .act_o     (act)
  );

  assign dir_wins = act[lk_inbound];

  atw_match #(
    .NUM_WIN   (NUM_WIN),
    .IDX_W     (IDX_W),
    .CFG_OFF_W (CFG_OFF_W)
  ) u_match (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wins_i  (dir_wins),
    .addr_i  (lk_addr),
    .hit_o   (lk_hit),
    .cfg_o   (lk_cfg),
    .xaddr_o (lk_xaddr),
    .bus_o   (lk_bus),
    .devfn_o (lk_devfn),
    .off_o   (lk_cfg_off),
    .idx_o   (lk_index)
  );

endmodule

// File: tb/atw_unit_tb_top.sv
`timescale 1ns/1ps
module atw_unit_tb_top;

  localparam int NUM_WIN = 4;
  localparam int CFG_OFF_W = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] lk_addr;
  logic        lk_inbound;
  logic        lk_hit, lk_cfg;
  logic [63:0] lk_xaddr;
  logic [7:0]  lk_bus, lk_devfn;
  logic [CFG_OFF_W-1:0] lk_cfg_off;
  logic [1:0]  lk_index;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  atw_unit #(.NUM_WIN(NUM_WIN), .CFG_OFF_W(CFG_OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_inbound(lk_inbound), .lk_hit(lk_hit), .lk_cfg(lk_cfg),
    .lk_xaddr(lk_xaddr), .lk_bus(lk_bus), .lk_devfn(lk_devfn),
    .lk_cfg_off(lk_cfg_off), .lk_index(lk_index)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read 0x%0h", a), 64'(reg_rdata), 64'(exp));
  endtask

  // Program base, limit, target of the selected window (no enable)
  task automatic prog(input logic [63:0] base, input logic [31:0] lim, input logic [63:0] tgt);
    wr(12'h90C, base[31:0]);
    wr(12'h910, base[63:32]);
    wr(12'h914, lim);
    wr(12'h918, tgt[31:0]);
    wr(12'h91C, tgt[63:32]);
  endtask

  task automatic lk_mem(input string req, input logic inb, input logic [63:0] a,
                        input logic exp_hit, input logic [1:0] exp_idx, input logic [63:0] exp_x);
    @(negedge clk);
    lk_inbound = inb; lk_addr = a;
    #1;
    chk(req, "hit", 64'(lk_hit), 64'(exp_hit));
    chk(req, "index", 64'(lk_index), 64'(exp_idx));
    chk(req, "xaddr", lk_xaddr, exp_x);
    chk(req, "cfg", 64'(lk_cfg), 64'd0);
  endtask

  task automatic t_reset();
    rd_chk("R1", 12'h900, 32'h0);
    rd_chk("R1", 12'h914, 32'hFFFF_FFFF);
    rd_chk("R1", 12'h908, 32'h0);
    lk_mem("R1", 1'b1, 64'h1234_5678, 1'b1, 2'd0, 64'h1234_5678);
    lk_mem("R1", 1'b1, 64'hFFFF_FFFF, 1'b1, 2'd0, 64'hFFFF_FFFF);
    lk_mem("R9", 1'b1, 64'h1_0000_0000, 1'b0, 2'd0, 64'h1_0000_0000);
    lk_mem("R1", 1'b0, 64'h1000, 1'b0, 2'd0, 64'h1000);
    wr(12'h900, 32'h8000_0000);
    rd_chk("R1", 12'h908, 32'h8000_0000);
  endtask

  task automatic t_viewport();
    wr(12'h900, 32'h8000_0002);
    rd_chk("R2", 12'h900, 32'h8000_0002);
    wr(12'h900, 32'h0000_0005);
    rd_chk("R2", 12'h900, 32'h0000_0005);
    wr(12'h90C, 32'h0000_0055);
    wr(12'h908, 32'h8000_0000);
    rd_chk("R2", 12'h90C, 32'h0);
    rd_chk("R2", 12'h914, 32'h0);
    for (int i = 0; i < NUM_WIN; i++) begin
      wr(12'h900, 32'(i));
      rd_chk("R2", 12'h90C, 32'h0);
      rd_chk("R2", 12'h908, 32'h0);
    end
    lk_mem("R2", 1'b0, 64'h55, 1'b0, 2'd0, 64'h55);
    // R11: unmapped offsets
    wr(12'h920, 32'hFFFF_FFFF);
    rd_chk("R11", 12'h920, 32'h0);
    rd_chk("R11", 12'h900, 32'h0000_0003);
  endtask

  task automatic t_shadow();
    wr(12'h900, 32'h0000_0001);
    prog(64'h1000, 32'h1FFF, 64'h2_9000_0000);
    lk_mem("R3", 1'b0, 64'h1800, 1'b0, 2'd0, 64'h1800);
    wr(12'h908, 32'h8000_0000);
    lk_mem("R3", 1'b0, 64'h1800, 1'b1, 2'd1, 64'h2_9000_0800);
    wr(12'h90C, 32'h3000);
    lk_mem("R3", 1'b0, 64'h1800, 1'b1, 2'd1, 64'h2_9000_0800);
    rd_chk("R3", 12'h90C, 32'h3000);
    rd_chk("R3", 12'h908, 32'h8000_0000);
    wr(12'h908, 32'h0);
    lk_mem("R3", 1'b0, 64'h1800, 1'b0, 2'd0, 64'h1800);
  endtask

  task automatic t_halves();
    wr(12'h910, 32'h7);
    rd_chk("R4", 12'h90C, 32'h3000);
    rd_chk("R4", 12'h910, 32'h7);
    wr(12'h918, 32'h1234);
    rd_chk("R4", 12'h91C, 32'h2);
    rd_chk("R4", 12'h918, 32'h1234);
    wr(12'h91C, 32'hA);
    rd_chk("R4", 12'h918, 32'h1234);
    rd_chk("R4", 12'h91C, 32'hA);
  endtask

  task automatic t_range();
    wr(12'h900, 32'h0000_0002);
    prog(64'h4000, 32'h4FFF, 64'h1_0000_0000);
    wr(12'h908, 32'h8000_0000);
    lk_mem("R5", 1'b0, 64'h3FFF, 1'b0, 2'd0, 64'h3FFF);
    lk_mem("R5", 1'b0, 64'h4000, 1'b1, 2'd2, 64'h1_0000_0000);
    lk_mem("R5", 1'b0, 64'h4FFF, 1'b1, 2'd2, 64'h1_0000_0FFF);
    lk_mem("R5", 1'b0, 64'h5000, 1'b0, 2'd0, 64'h5000);
    lk_mem("R5", 1'b0, 64'h1_0000_4000, 1'b0, 2'd0, 64'h1_0000_4000);
    lk_mem("R6", 1'b0, 64'h4010, 1'b1, 2'd2, 64'h1_0000_0010);
    wr(12'h900, 32'h0000_0003);
    prog(64'h8000, 32'h7000, 64'h0);
    wr(12'h908, 32'h8000_0000);
    lk_mem("R5", 1'b0, 64'h7800, 1'b0, 2'd0, 64'h7800);
    lk_mem("R5", 1'b0, 64'h8000, 1'b0, 2'd0, 64'h8000);
  endtask

  task automatic t_cfg();
    wr(12'h900, 32'h0000_0000);
    wr(12'h904, 32'h4);
    rd_chk("R7", 12'h904, 32'h4);
    prog(64'hA000_0000, 32'hA000_FFFF, 64'h0312_0000);
    wr(12'h908, 32'h8000_0000);
    @(negedge clk);
    lk_inbound = 1'b0; lk_addr = 64'hA000_0ABC;
    #1;
    chk("R7", "hit", 64'(lk_hit), 64'd1);
    chk("R7", "cfg", 64'(lk_cfg), 64'd1);
    chk("R7", "bus", 64'(lk_bus), 64'h03);
    chk("R7", "devfn", 64'(lk_devfn), 64'h12);
    chk("R7", "offset", 64'(lk_cfg_off), 64'hABC);
    chk("R7", "index", 64'(lk_index), 64'd0);
    lk_mem("R7", 1'b0, 64'h4020, 1'b1, 2'd2, 64'h1_0000_0020);
  endtask

  task automatic t_prio();
    wr(12'h900, 32'h0000_0003);
    prog(64'h4000, 32'h4FFF, 64'h7_0000_0000);
    wr(12'h908, 32'h8000_0000);
    lk_mem("R8", 1'b0, 64'h4100, 1'b1, 2'd2, 64'h1_0000_0100);
    wr(12'h900, 32'h0000_0002);
    wr(12'h908, 32'h0);
    lk_mem("R8", 1'b0, 64'h4100, 1'b1, 2'd3, 64'h7_0000_0100);
  endtask

  task automatic t_dir();
    lk_mem("R10", 1'b1, 64'h4100, 1'b1, 2'd0, 64'h4100);
    wr(12'h900, 32'h8000_0001);
    prog(64'h1000, 32'h1FFF, 64'h5_0000);
    wr(12'h908, 32'h8000_0000);
    lk_mem("R8", 1'b1, 64'h1800, 1'b1, 2'd0, 64'h1800);
    wr(12'h900, 32'h8000_0000);
    wr(12'h908, 32'h0);
    lk_mem("R10", 1'b1, 64'h1800, 1'b1, 2'd1, 64'h5_0800);
    lk_mem("R9", 1'b1, 64'h3000, 1'b0, 2'd0, 64'h3000);
    lk_mem("R10", 1'b0, 64'h1800, 1'b0, 2'd0, 64'h1800);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 12'h0; reg_wdata = 32'h0;
    lk_addr = 64'h0; lk_inbound = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_viewport();
    t_shadow();
    t_halves();
    t_range();
    t_cfg();
    t_prio();
    t_dir();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule